// File: doc/BRIEF.md
# Shadow-Capture Pipeline Register

This block is a pipeline register stage for feed-forward datapaths that are clocked faster than their worst-case path allows. The main register takes the input on the rising edge of the main clock. A second register, the shadow copy, takes the same input on the rising edge of a delayed clock, which is the main clock shifted by a fixed part of a period. Data that settles after the main edge but before the delayed edge therefore reaches only the shadow copy.

During the cycle after a load from the input, the stage compares the two copies. If they differ, the next main edge loads the shadow value into the main register in place of the input. A one-cycle stall request then goes to the surrounding pipeline, and the edge that ends the stall cycle does not sample the input. If the copies agree, data moves on with no stall. A saturating counter tracks how many corrections have been made. The stage has one asynchronous active-low reset, which is released into each clock domain through a small synchronizer.

Top module: `rz_shadow_reg`

## Requirements
- R1: While reset is asserted, `q_o`, `err_o` and `cnt_o` are all zero. They are cleared as soon as reset asserts, without waiting for a clock edge.
- R2: When the input is stable across both the main edge and the delayed edge, and no correction or stall is in progress, `q_o` takes the input value from that main edge and `err_o` stays low.
- R3: If the input changes between a main edge and the following delayed edge, the next main edge loads `q_o` with the value taken at the delayed edge. The input present at that main edge is not loaded.
- R4: `err_o` is high for exactly one cycle. It rises at the main edge that loads the shadow value (R3) and falls at the edge after that.
- R5: At the main edge that ends a cycle with `err_o` high, `q_o` holds its corrected value and the input at that edge is ignored.
- R6: The two copies are compared only after a main edge that loaded the input. An edge that corrects or holds is never followed by another correction, so `err_o` stays low when data arrives on time.
- R7: `cnt_o` increases by exactly one at each correcting edge and does not change at any other edge.
- R8: Once `cnt_o` is all ones, it stays there until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Main clock |
| clk_dly_i | input | 1 | Delayed copy of the main clock, used for the shadow capture |
| rst_ni | input | 1 | Asynchronous active-low reset |
| d_i | input | W | Data from the upstream logic |
| q_o | output | W | Registered (possibly corrected) data |
| err_o | output | 1 | One-cycle stall request after a correction |
| cnt_o | output | CNT_W | Saturating count of corrections |

## Verification
The properties assume that `clk_dly_i` is `clk_i` delayed by a fixed amount of less than one period. They also assume that `d_i` never changes exactly at a delayed edge, so the shadow copy always holds a settled value. The stimulus changes the input only at two fixed offsets from the main edge. An on-time change comes half a period before the main edge. A late change comes a fraction of a nanosecond after the main edge, which is before the delayed edge. Both offsets stay clear of every clock edge. A random mix of on-time and late changes, including back-to-back late ones, is compared against a cycle model written from the requirements. Directed runs drive the counter into saturation and apply a reset in the middle of traffic.

// File: rtl/rz_pkg.sv
package rz_pkg;

  // Action taken by the main register at a main clock edge
  typedef enum logic [1:0] {
    ACT_LOAD = 2'd0,  // take the input
    ACT_FIX  = 2'd1,  // replace with shadow copy, raise stall
    ACT_HOLD = 2'd2   // stall cycle: keep corrected value
  } rz_act_e;

endpackage

// File: rtl/rz_rst_sync.sv
module rz_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/rz_shadow_cap.sv
module rz_shadow_cap #(
  parameter int W = 32
) (
  input  logic         clk_dly_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] shadow_o
);
  logic [W-1:0] shadow_q;

  always_ff @(posedge clk_dly_i or negedge rst_ni) begin
    if (!rst_ni) shadow_q <= '0;
    else         shadow_q <= d_i;
  end

  assign shadow_o = shadow_q;
endmodule

// File: rtl/rz_main_stage.sv
module rz_main_stage
  import rz_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  input  logic [W-1:0] shadow_i,
  output logic [W-1:0] q_o,
  output logic         stall_o,
  output logic         fix_o
);
  logic [W-1:0] main_q, main_d;
  logic         stall_q, stall_d;
  logic         armed_q, armed_d;   // main_q was loaded from d_i at last edge
  logic         main_en;
  logic         mismatch;
  rz_act_e      act;

  always_comb begin
    mismatch = (main_q != shadow_i);
    fix_o    = armed_q & mismatch;
    if (stall_q)    act = ACT_HOLD;
    else if (fix_o) act = ACT_FIX;
    else            act = ACT_LOAD;

    main_d  = main_q;
    stall_d = 1'b0;
    armed_d = 1'b0;
    unique case (act)
      ACT_LOAD: begin main_d = d_i;      armed_d = 1'b1; end
      ACT_FIX:  begin main_d = shadow_i; stall_d = 1'b1; end
      default:  begin end
    endcase
    main_en = (act != ACT_HOLD);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      main_q  <= '0;
      stall_q <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (main_en) main_q <= main_d;
      stall_q <= stall_d;
      armed_q <= armed_d;
    end
  end

  assign q_o     = main_q;
  assign stall_o = stall_q;
endmodule

// File: rtl/rz_err_counter.sv
module rz_err_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = inc_i & (cnt_q != CNT_MAX);
    cnt_d  = cnt_q + CNT_ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rz_shadow_reg.sv
module rz_shadow_reg #(
  parameter int W        = 32,
  parameter int CNT_W    = 8,
  parameter int SYNC_LEN = 2
) (
  input  logic             clk_i,
  input  logic             clk_dly_i,
  input  logic             rst_ni,
  input  logic [W-1:0]     d_i,
  output logic [W-1:0]     q_o,
  output logic             err_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic         rst_main_n;
  logic         rst_dly_n;
  logic [W-1:0] shadow_w;
  logic         fix_w;

  rz_rst_sync #(.STAGES(SYNC_LEN)) u_rst_main (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_no(rst_main_n)
  );

  rz_rst_sync #(.STAGES(SYNC_LEN)) u_rst_dly (
    .clk_i(clk_dly_i), .rst_ni(rst_ni), .rst_no(rst_dly_n)
  );

  rz_shadow_cap #(.W(W)) u_shadow (
    .clk_dly_i(clk_dly_i), .rst_ni(rst_dly_n), .d_i(d_i), .shadow_o(shadow_w)
  );

  rz_main_stage #(.W(W)) u_main (
    .clk_i(clk_i), .rst_ni(rst_main_n), .d_i(d_i), .shadow_i(shadow_w),
    .q_o(q_o), .stall_o(err_o), .fix_o(fix_w)
  );

  rz_err_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_main_n), .inc_i(fix_w), .cnt_o(cnt_o)
  );
endmodule

// File: rtl/rz_shadow_reg_chk.sv
module rz_shadow_reg_chk #(
  parameter int W     = 32,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [W-1:0]     q,
  input logic [W-1:0]     shadow,
  input logic             err,
  input logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] C_MAX = '1;
  localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);

  // R4: stall request lasts a single cycle
  p_err_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

  // R5: corrected value held across the stall cycle
  p_hold_in_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> $stable(q));

  // R3: correction takes the shadow copy seen at the correcting edge
  p_fix_from_shadow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> (q == $past(shadow)));

  // R7: counter moves only by one and only on a correction
  p_cnt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> ((cnt == $past(cnt) + C_ONE) && $rose(err)));

  // R8: counter sticks at its maximum
  p_cnt_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt) == C_MAX) |-> (cnt == C_MAX));
endmodule

bind rz_shadow_reg rz_shadow_reg_chk #(.W(W), .CNT_W(CNT_W)) u_chk (
  .clk(clk_i), .rst_n(rst_ni), .q(q_o), .shadow(shadow_w),
  .err(err_o), .cnt(cnt_o)
);

// File: tb/sim_rz_shadow_reg.sv
module sim_rz_shadow_reg;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int W     = 8;
  localparam int CNT_W = 4;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic             clk, clk_dly, rst_n;
  logic [W-1:0]     d, q;
  logic             err;
  logic [CNT_W-1:0] cnt;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // reference model state
  logic [W-1:0] m_q, m_sh, m_prev;
  bit           m_stall, m_arm;
  int           m_cnt;

  rz_shadow_reg #(.W(W), .CNT_W(CNT_W)) u0 (
    .clk_i(clk), .clk_dly_i(clk_dly), .rst_ni(rst_n),
    .d_i(d), .q_o(q), .err_o(err), .cnt_o(cnt)
  );

  // 250 MHz main clock, delayed copy 1 ns later
  initial begin clk = 0; forever #2 clk = ~clk; end
  initial begin clk_dly = 0; #1; forever #2 clk_dly = ~clk_dly; end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void model_after_reset();
    m_q = '0; m_sh = '0; m_prev = '0;
    m_stall = 0; m_arm = 1; m_cnt = 0;
  endfunction

  // one main edge; called at a falling edge of clk
  task automatic step(logic [W-1:0] v, bit late);
    logic [W-1:0] dm;
    bit fixed, held;
    if (!late) d = v;
    @(posedge clk);
    #0.5;
    if (late) d = v;
    #1.0;
    dm = late ? m_prev : v;
    fixed = 0; held = 0;
    if (m_stall) begin
      m_stall = 0; m_arm = 0; held = 1;
    end else if (m_arm && (m_q != m_sh)) begin
      m_q = m_sh; m_stall = 1; m_arm = 0; fixed = 1;
      if (m_cnt < CMAX) m_cnt++;
    end else begin
      m_q = dm; m_arm = 1;
    end
    m_sh = v; m_prev = v;
    chk(fixed ? "R3" : (held ? "R5" : "R2"), int'(q), int'(m_q));
    chk(fixed ? "R4" : (held ? "R4" : "R6"), int'(err), int'(m_stall));
    chk((m_cnt == CMAX) ? "R8" : "R7", int'(cnt), m_cnt);
    @(negedge clk);
  endtask

  task automatic check_reset_state();
    chk("R1", int'(q), 0);
    chk("R1", int'(err), 0);
    chk("R1", int'(cnt), 0);
  endtask

  initial begin
    void'($urandom(32'd24680));
    rst_n = 0; d = '0;
    repeat (3) @(negedge clk);
    check_reset_state();
    rst_n = 1;
    repeat (4) @(negedge clk);
    model_after_reset();

    // directed: on-time traffic, one late item, stall, same-value late
    step(8'h3C, 0); step(8'hA5, 0);
    step(8'h5A, 1);
    step(8'h11, 0); step(8'h22, 0); step(8'h33, 0);
    step(8'h33, 1); step(8'h44, 0);
    // back-to-back late items
    step(8'h0F, 1); step(8'hF0, 1); step(8'h77, 1); step(8'h01, 0);
    step(8'h02, 0); step(8'h03, 0);

    // random mix
    for (int i = 0; i < 600; i++) begin
      step(W'($urandom), (($urandom % 4) == 0));
    end

    // drive the counter into saturation
    for (int i = 0; i < CMAX + 4; i++) begin
      step(W'($urandom), 1);
      step(W'($urandom), 0);
      step(W'($urandom), 0);
    end

    // reset in the middle of traffic
    rst_n = 0;
    #1;
    check_reset_state();
    d = '0;
    @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    model_after_reset();
    for (int i = 0; i < 40; i++) begin
      step(W'($urandom), (($urandom % 3) == 0));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule